// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Prescaler

This block is a supervisory timer for a processor subsystem. A slow time-base tick, given to it as a single-cycle enable in the system clock domain, feeds a prescaler. The prescaler divides the tick by a power of two chosen by a 4-bit select field. Each prescaler output step advances an 8-bit counter. Once software turns the watchdog on, the counter must be kicked regularly with a clear strobe. If the counter wraps past its top value, the block issues a one-cycle reset request to the chip reset controller.

A static input, driven from non-volatile configuration, keeps the watchdog off whatever the software enable holds. A watchdog timeout restores the enable and the divider select to their power-up values. It also sets a sticky flag, which lets software tell after start-up that the last reset came from the watchdog. Only the external reset clears that flag.

Top module: `wdog_timer`

## Requirements
- R1: After the external reset `rst_ni`, `reg_rdata_o` reads 8'h04 and `rst_req_o` is 0. The register layout is: bit 7 is the enable, bit 6 is the clear strobe (it reads 0), bit 5 is the timeout flag, bit 4 reads 0, and bits 3:0 are the divider select, which resets to 4'b0100.
- R2: While the watchdog runs, a reset request follows exactly 256 × 2^div ticks of `tick_i`, where div is bits 3:0. The count starts from the point the watchdog was enabled or cleared. Idle cycles between ticks do not change this count.
- R3: `rst_req_o` is high for exactly one clock cycle. It rises in the cycle after the clock edge that sampled the final tick.
- R4: While `fuse_off_i` is 1, the watchdog neither counts nor requests a reset, even when the enable bit reads 1.
- R5: While the watchdog does not run (enable 0 or `fuse_off_i` 1), the prescaler and counter are held at zero. Once it runs again, a full timeout period is needed.
- R6: A register write with bit 6 set zeroes the prescaler and the counter at that clock edge. A tick in that same cycle is discarded. If the write lands in the cycle that would otherwise overflow, no reset request is issued.
- R7: Any register write also loads the enable from bit 7 and the divider select from bits 3:0. A timeout clears the enable, restores the divider select to 4'b0100 and sets the flag, so that `reg_rdata_o` reads 8'h24.
- R8: Register writes leave the flag unchanged, and a further timeout keeps it at 1. Only `rst_ni` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | External reset, asynchronous, active low |
| tick_i | input | 1 | Single-cycle time-base tick enable |
| fuse_off_i | input | 1 | Static disable; 1 forces the watchdog off |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The reset request is registered. It is therefore visible in the cycle after the clock edge that samples the final tick. Register effects appear in the cycle after the write edge. The bench drives each tick or write at a falling edge and reads the outputs at the next falling edge, so that edge lands exactly where each result is due. Timeouts are measured as the number of ticks until the request appears, so an off-by-one in the prescaler or the counter shows up directly as a wrong count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned EN_BIT      = 7;
  localparam int unsigned CLR_BIT     = 6;
  localparam int unsigned FLAG_BIT    = 5;
  localparam int unsigned DIV_LSB     = 0;
  localparam int unsigned DIV_W_DEF   = 4;
  localparam int unsigned CNT_W_DEF   = 8;
  localparam logic [DIV_W_DEF-1:0] DIV_RST = 4'b0100;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_W = wdog_pkg::DIV_W_DEF,
  localparam int unsigned PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   mask_full;
  logic [PRE_W-1:0] mask;

  // low div_i bits all ones -> pass this tick
  assign mask_full = ((PRE_W+1)'(1) << div_i) - (PRE_W+1)'(1);
  assign mask      = mask_full[PRE_W-1:0];
  assign step_o    = run_i & tick_i & ~clr_i & ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || clr_i)   pre_q <= '0;
    else if (tick_i)            pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_HELD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || clr_i) |=> (pre_q == '0)); // R5
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = wdog_pkg::CNT_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic step_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = run_i & step_i & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || clr_i || ovf_o)    cnt_q <= '0;
    else if (step_i)                      cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_HELD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || clr_i) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int unsigned DIV_W = wdog_pkg::DIV_W_DEF,
  parameter logic [DIV_W-1:0] DIV_RST = wdog_pkg::DIV_RST
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [wdog_pkg::REG_W-1:0] wdata_i,
  input  logic                       ovf_i,
  output logic                       en_o,
  output logic                       clr_o,
  output logic [DIV_W-1:0]           div_o,
  output logic [wdog_pkg::REG_W-1:0] rdata_o
);
  import wdog_pkg::*;

  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << EN_BIT) | (1 << CLR_BIT) | (((1 << DIV_W) - 1) << DIV_LSB));

  logic             en_q, flag_q;
  logic [DIV_W-1:0] div_q;
  logic             unused_wbits;

  assign unused_wbits = ^(wdata_i & ~USED_MASK);
  assign clr_o = we_i & wdata_i[CLR_BIT];
  assign en_o  = en_q;
  assign div_o = div_q;

  // timeout takes priority over a write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      div_q  <= DIV_RST;
      flag_q <= 1'b0;
    end else if (ovf_i) begin
      en_q   <= 1'b0;
      div_q  <= DIV_RST;
      flag_q <= 1'b1;
    end else if (we_i) begin
      en_q   <= wdata_i[EN_BIT];
      div_q  <= wdata_i[DIV_LSB +: DIV_W];
    end
  end

  always_comb begin
    rdata_o                    = '0;
    rdata_o[EN_BIT]            = en_q;
    rdata_o[FLAG_BIT]          = flag_q;
    rdata_o[DIV_LSB +: DIV_W]  = div_q;
  end

  AST_TIMEOUT_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (!en_q && flag_q && div_q == DIV_RST)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W = wdog_pkg::CNT_W_DEF,
  parameter int unsigned DIV_W = wdog_pkg::DIV_W_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fuse_off_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       rst_req_o
);
  logic             en, clr, run, step, ovf;
  logic [DIV_W-1:0] div;
  logic             rst_req_q;

  assign run = en & ~fuse_off_i;

  wdog_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_W'(wdog_pkg::DIV_RST))) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .ovf_i(ovf),
    .en_o(en), .clr_o(clr), .div_o(div), .rdata_o(reg_rdata_o)
  );

  wdog_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .tick_i, .div_i(div), .step_o(step)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .clr_i(clr), .step_i(step), .ovf_o(ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= ovf;
  end

  assign rst_req_o = rst_req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q); // R3
  AST_FUSE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fuse_off_i) |-> !rst_req_q); // R4
  AST_CLR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !rst_req_q); // R6
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       fuse = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req;

  int n_chk = 0;
  int n_fail = 0;

  localparam int NV = 5;
  localparam int VEC_DIV [NV] = '{0, 1, 2, 3, 1};
  localparam int VEC_GAP [NV] = '{0, 0, 0, 0, 2};

  always #2 clk = ~clk;

  wdog_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .fuse_off_i(fuse),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_req_o(rst_req)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // returns tick index at which the request appeared, 0 if none
  task automatic run_ticks(int maxn, int gap, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      repeat (gap) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (rst_req) begin n = i; break; end
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 8'h04);
    chk("R1 reset req", rst_req, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 rdata after release", rdata, 8'h04);

    wr(8'h34);
    chk("R8 flag write ignored", rdata, 8'h04);

    for (int v = 0; v < NV; v++) begin
      wr(8'h80 | 8'(VEC_DIV[v]));
      run_ticks((256 << VEC_DIV[v]) + 16, VEC_GAP[v], n);
      chk($sformatf("R2 timeout div=%0d gap=%0d", VEC_DIV[v], VEC_GAP[v]), n, 256 << VEC_DIV[v]);
      @(negedge clk);
      chk("R3 request one cycle", rst_req, 0);
      chk("R7 regs after timeout", rdata, 8'h24);
    end
    chk("R8 flag kept over repeated timeouts", rdata[5], 1);

    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 external reset clears flag", rdata, 8'h04);

    fuse = 1'b1;
    wr(8'h80);
    chk("R4 enable reads back under fuse", rdata, 8'h80);
    run_ticks(600, 0, n);
    chk("R4 no request under fuse", n, 0);
    fuse = 1'b0;
    run_ticks(300, 0, n);
    chk("R5 full period after fuse released", n, 256);

    wr(8'h80);
    run_ticks(200, 0, n);
    chk("R5 no early request", n, 0);
    wr(8'h00);
    run_ticks(100, 0, n);
    chk("R5 disabled no request", n, 0);
    wr(8'h80);
    run_ticks(300, 0, n);
    chk("R5 full period after re-enable", n, 256);

    wr(8'h80);
    run_ticks(200, 0, n);
    wr(8'hC0);
    run_ticks(300, 0, n);
    chk("R6 clear restarts counter", n, 256);

    wr(8'h82);
    run_ticks(3, 0, n);
    wr(8'hC2);
    run_ticks(1100, 0, n);
    chk("R6 clear restarts prescaler", n, 1024);

    wr(8'h80);
    run_ticks(255, 0, n);
    chk("R6 no request before final tick", n, 0);
    tick = 1'b1; we = 1'b1; wdata = 8'hC0;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    chk("R6 clear beats overflow", rst_req, 0);
    run_ticks(300, 0, n);
    chk("R6 full period after clear at overflow", n, 256);

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end
endmodule